// File: doc/BRIEF.md
# Framed Event-Link Receiver with Alternating-Parity Check

This block sits behind a serial-link transceiver and consumes one 16-bit word per link clock, each qualified by an enable bit and an error/extend bit. It sorts every word into one of three classes: idle, carrier-extend or data. It finds event frames in that stream and captures each one. A frame is a header word, then a clock-counter word, then a fixed number of payload words (twelve by default), so a full frame fills fourteen link slots. The sender runs from a clock that is not locked to the link clock, so any number of filler words may appear between frames.

Every payload word is checked against a parity phase that starts at each header and flips from word to word. Frames with too few or too many payload words are dropped. Successive frames must carry clock-counter values that step by exactly one, modulo 2^16. A frame that passes the structure checks is offered to the consumer on a valid/ready port, together with one parity flag per payload word. Saturating counters record each kind of fault.

Top module: `evlink_rx`

## Requirements
- R1: Word classes follow the qualifiers. rxEn=1 marks a data word whatever the value of rxErrExt. rxEn=0 with rxErrExt=0 marks idle. rxEn=0 with rxErrExt=1 marks carrier-extend.
- R2: After reset, data words are ignored until the first non-data word has been seen. Outside a frame, the first data word that follows a non-data word is taken as the header, and the next data word is taken as the clock counter.
- R3: A frame completes when a non-data word (idle or carrier-extend) follows its N-th payload word. frmValid rises on the clock edge that samples this terminating word. frmHeader and frmClock then show the header and clock words, and payload word i is on frmPayload[16i+15:16i].
- R4: A carrier-extend word between the header and the N-th payload word is skipped. It is not counted as payload and does not end the frame.
- R5: An idle word that arrives after the header but before the N-th payload word drops the frame and adds one to truncCount.
- R6: A data word that arrives after the N-th payload word drops the frame and adds one to longCount. Further data words are then ignored until a non-data word arrives.
- R7: Payload word i is expected to have an XOR-reduction equal to i mod 2, so word 0 has even parity. frmParErr[i] is 1 when word i of the presented frame missed this. parCount adds one for each mismatching payload word as it arrives.
- R8: While frmValid=1 and frmReady=0, frmValid, frmHeader, frmClock, frmPayload and frmParErr hold their values. A cycle with frmValid=1 and frmReady=1 and no new completion clears frmValid.
- R9: A frame that completes while frmValid=1 and frmReady=0 is discarded and adds one to ovflCount. The held frame is left unchanged. If frmReady=1 in the completing cycle, the new frame replaces the old one and ovflCount does not change.
- R10: Every completed frame, including one discarded under R9, has its clock word compared with the clock word of the previous completed frame plus one, modulo 2^16. The first frame after reset is not compared. A mismatch adds one to seqCount and sets seqSticky, which stays set until reset.
- R11: Reset clears frmValid, seqSticky and all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEn | input | 1 | Word-enable qualifier from the transceiver |
| rxErrExt | input | 1 | Error/extend qualifier from the transceiver |
| rxData | input | 16 | Received word |
| frmValid | output | 1 | A captured frame is on offer |
| frmReady | input | 1 | Consumer takes the offered frame |
| frmHeader | output | 16 | Header word of the offered frame |
| frmClock | output | 16 | Clock-counter word of the offered frame |
| frmPayload | output | 192 | Payload words, word i on bits 16i+15..16i |
| frmParErr | output | 12 | Parity miss per payload word |
| truncCount | output | 16 | Frames dropped as too short (saturating) |
| longCount | output | 16 | Frames dropped as too long (saturating) |
| parCount | output | 16 | Payload words with wrong parity (saturating) |
| seqCount | output | 16 | Clock-counter sequence faults (saturating) |
| ovflCount | output | 16 | Frames lost to a full output slot (saturating) |
| seqSticky | output | 1 | At least one sequence fault since reset |

## Verification
Frame delivery and consumer hand-off can fall in the same cycle: a frame's terminating word is sampled on the same edge on which frmReady takes the frame already on offer. The bench provokes this by raising frmReady in exactly the cycle that presents the terminator. It counts this case correct only if frmValid stays high, the new header replaces the old one and ovflCount stays unchanged. For comparison, the same sequence is also run with frmReady held low, and there the counter must step and the old frame must stay in place.

// File: rtl/evlink_pkg.sv
package evlink_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_GAP,
    ST_CLK,
    ST_PAY,
    ST_DONE
  } rxState_e;

  typedef enum logic [1:0] {
    WC_IDLE,
    WC_EXT,
    WC_DATA
  } wordClass_e;

  typedef struct packed {
    logic capHdr;
    logic capClk;
    logic capPay;
    logic commit;
    logic truncErr;
    logic longErr;
  } rxStrobe_t;

  function automatic wordClass_e classifyWord(input logic en, input logic ext);
    if (en) return WC_DATA;
    else if (ext) return WC_EXT;
    else return WC_IDLE;
  endfunction

endpackage

// File: rtl/evlink_satcnt.sv
module evlink_satcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inc,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (inc && !(&count)) count <= count + CW'(1);
  end

endmodule

// File: rtl/evlink_ctrl.sv
module evlink_ctrl
  import evlink_pkg::*;
#(
  parameter int N  = 12,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxEn,
  input  logic          rxErrExt,
  output rxStrobe_t     strb,
  output logic [IW-1:0] payIdx
);

  localparam logic [IW-1:0] LastIdx = IW'(N - 1);

  rxState_e      state, nextState;
  logic [IW-1:0] idxQ, nextIdx;
  wordClass_e    cls;

  assign payIdx = idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HUNT;
      idxQ  <= '0;
    end else begin
      state <= nextState;
      idxQ  <= nextIdx;
    end
  end

  always_comb begin
    cls       = classifyWord(rxEn, rxErrExt);
    strb      = '0;
    nextState = state;
    nextIdx   = idxQ;
    unique case (state)
      ST_HUNT: begin
        if (cls != WC_DATA) nextState = ST_GAP;
      end
      ST_GAP: begin
        if (cls == WC_DATA) begin
          strb.capHdr = 1'b1;
          nextState   = ST_CLK;
        end
      end
      ST_CLK: begin
        if (cls == WC_DATA) begin
          strb.capClk = 1'b1;
          nextIdx     = '0;
          nextState   = ST_PAY;
        end else if (cls == WC_IDLE) begin
          strb.truncErr = 1'b1;
          nextState     = ST_GAP;
        end
      end
      ST_PAY: begin
        if (cls == WC_DATA) begin
          strb.capPay = 1'b1;
          if (idxQ == LastIdx) nextState = ST_DONE;
          else nextIdx = idxQ + IW'(1);
        end else if (cls == WC_IDLE) begin
          strb.truncErr = 1'b1;
          nextState     = ST_GAP;
        end
      end
      ST_DONE: begin
        if (cls == WC_DATA) begin
          strb.longErr = 1'b1;
          nextState    = ST_HUNT;
        end else begin
          strb.commit = 1'b1;
          nextState   = ST_GAP;
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

endmodule

// File: rtl/evlink_dpath.sv
module evlink_dpath
  import evlink_pkg::*;
#(
  parameter int W  = 16,
  parameter int N  = 12,
  parameter int CW = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [W-1:0]   rxData,
  input  rxStrobe_t      strb,
  input  logic [IW-1:0]  payIdx,
  input  logic           frmReady,
  output logic           frmValid,
  output logic [W-1:0]   frmHeader,
  output logic [W-1:0]   frmClock,
  output logic [N*W-1:0] frmPayload,
  output logic [N-1:0]   frmParErr,
  output logic [CW-1:0]  truncCount,
  output logic [CW-1:0]  longCount,
  output logic [CW-1:0]  parCount,
  output logic [CW-1:0]  seqCount,
  output logic [CW-1:0]  ovflCount,
  output logic           seqSticky
);

  localparam int NumCnt = 5;

  logic [W-1:0] capHdrQ, capClkQ, lastClkQ;
  logic [W-1:0] capPayQ [N];
  logic [N-1:0] capParQ;
  logic         haveLastQ;
  logic         parMiss, seqMiss, overflow, loadOut;

  assign parMiss  = strb.capPay && ((^rxData) != payIdx[0]);
  assign seqMiss  = strb.commit && haveLastQ && (capClkQ != lastClkQ + W'(1));
  assign overflow = strb.commit && frmValid && !frmReady;
  assign loadOut  = strb.commit && !overflow;

  // capture buffer for the frame being assembled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capHdrQ <= '0;
      capClkQ <= '0;
      capParQ <= '0;
      for (int i = 0; i < N; i++) capPayQ[i] <= '0;
    end else begin
      if (strb.capHdr) begin
        capHdrQ <= rxData;
        capParQ <= '0;
      end
      if (strb.capClk) capClkQ <= rxData;
      if (strb.capPay) begin
        capPayQ[payIdx] <= rxData;
        capParQ[payIdx] <= parMiss;
      end
    end
  end

  // clock-counter continuity across completed frames
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastClkQ  <= '0;
      haveLastQ <= 1'b0;
      seqSticky <= 1'b0;
    end else if (strb.commit) begin
      lastClkQ  <= capClkQ;
      haveLastQ <= 1'b1;
      if (seqMiss) seqSticky <= 1'b1;
    end
  end

  // single output slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmValid   <= 1'b0;
      frmHeader  <= '0;
      frmClock   <= '0;
      frmPayload <= '0;
      frmParErr  <= '0;
    end else if (loadOut) begin
      frmValid  <= 1'b1;
      frmHeader <= capHdrQ;
      frmClock  <= capClkQ;
      frmParErr <= capParQ;
      for (int i = 0; i < N; i++) frmPayload[i*W +: W] <= capPayQ[i];
    end else if (frmValid && frmReady) begin
      frmValid <= 1'b0;
    end
  end

  logic [NumCnt-1:0] incVec;
  logic [CW-1:0]     cntQ [NumCnt];

  assign incVec = {overflow, seqMiss, parMiss, strb.longErr, strb.truncErr};

  for (genvar g = 0; g < NumCnt; g++) begin : g_cnt
    evlink_satcnt #(.CW(CW)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (incVec[g]),
      .count(cntQ[g])
    );
  end

  assign truncCount = cntQ[0];
  assign longCount  = cntQ[1];
  assign parCount   = cntQ[2];
  assign seqCount   = cntQ[3];
  assign ovflCount  = cntQ[4];

endmodule

// File: rtl/evlink_rx.sv
module evlink_rx
  import evlink_pkg::*;
#(
  parameter int W  = 16,
  parameter int N  = 12,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           rxEn,
  input  logic           rxErrExt,
  input  logic [W-1:0]   rxData,
  output logic           frmValid,
  input  logic           frmReady,
  output logic [W-1:0]   frmHeader,
  output logic [W-1:0]   frmClock,
  output logic [N*W-1:0] frmPayload,
  output logic [N-1:0]   frmParErr,
  output logic [CW-1:0]  truncCount,
  output logic [CW-1:0]  longCount,
  output logic [CW-1:0]  parCount,
  output logic [CW-1:0]  seqCount,
  output logic [CW-1:0]  ovflCount,
  output logic           seqSticky
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  rxStrobe_t     strb;
  logic [IW-1:0] payIdx;

  evlink_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxEn    (rxEn),
    .rxErrExt(rxErrExt),
    .strb    (strb),
    .payIdx  (payIdx)
  );

  evlink_dpath #(.W(W), .N(N), .CW(CW), .IW(IW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .rxData    (rxData),
    .strb      (strb),
    .payIdx    (payIdx),
    .frmReady  (frmReady),
    .frmValid  (frmValid),
    .frmHeader (frmHeader),
    .frmClock  (frmClock),
    .frmPayload(frmPayload),
    .frmParErr (frmParErr),
    .truncCount(truncCount),
    .longCount (longCount),
    .parCount  (parCount),
    .seqCount  (seqCount),
    .ovflCount (ovflCount),
    .seqSticky (seqSticky)
  );

endmodule

// File: rtl/evlink_rx_chk.sv
module evlink_rx_chk
  import evlink_pkg::*;
#(
  parameter int W  = 16,
  parameter int N  = 12,
  parameter int CW = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           rxEn,
  input logic           frmValid,
  input logic           frmReady,
  input logic [W-1:0]   frmHeader,
  input logic [W-1:0]   frmClock,
  input logic [N*W-1:0] frmPayload,
  input logic [N-1:0]   frmParErr,
  input logic [CW-1:0]  truncCount,
  input logic [CW-1:0]  ovflCount,
  input logic           seqSticky,
  input rxStrobe_t      strb
);

  // R3: a frame appears only after a non-data terminating word
  a_r3_after_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmValid) |-> $past(!rxEn));

  // R8: offered frame is held while the consumer stalls
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && !frmReady |=> frmValid && $stable(frmHeader) && $stable(frmClock)
                              && $stable(frmPayload) && $stable(frmParErr));

  // R9: completion into a stalled slot bumps the overflow counter
  a_r9_no_overflow_miss: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && frmValid && !frmReady && !(&ovflCount) |=> ovflCount == $past(ovflCount) + CW'(1));

  // R10: sequence flag never clears outside reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(seqSticky));

  // R5: truncation counter moves by at most one per word
  a_r5_trunc_step: assert property (@(posedge clk) disable iff (!rstN)
    (truncCount == $past(truncCount)) || (truncCount == $past(truncCount) + CW'(1)));

  // R6: the word after an overlong fault never opens a frame
  a_r6_hunt: assert property (@(posedge clk) disable iff (!rstN)
    strb.longErr |=> !strb.capHdr);

endmodule

bind evlink_rx evlink_rx_chk #(.W(W), .N(N), .CW(CW)) u_chk (.*);

// File: tb/evlink_rx_bench.sv
`timescale 1ns/1ps
module evlink_rx_bench;

  localparam int W  = 16;
  localparam int N  = 12;
  localparam int CW = 16;

  logic           clk = 1'b0;
  logic           rstN, rxEn, rxErrExt, frmReady;
  logic [W-1:0]   rxData;
  logic           frmValid, seqSticky;
  logic [W-1:0]   frmHeader, frmClock;
  logic [N*W-1:0] frmPayload;
  logic [N-1:0]   frmParErr;
  logic [CW-1:0]  truncCount, longCount, parCount, seqCount, ovflCount;

  always #2.5 clk = ~clk;

  evlink_rx #(.W(W), .N(N), .CW(CW)) u_evlink_rx (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .rxErrExt(rxErrExt), .rxData(rxData),
    .frmValid(frmValid), .frmReady(frmReady), .frmHeader(frmHeader),
    .frmClock(frmClock), .frmPayload(frmPayload), .frmParErr(frmParErr),
    .truncCount(truncCount), .longCount(longCount), .parCount(parCount),
    .seqCount(seqCount), .ovflCount(ovflCount), .seqSticky(seqSticky)
  );

  int nChecks = 0;
  int nFails  = 0;
  int expTrunc = 0, expLong = 0, expPar = 0, expSeq = 0, expOvfl = 0;
  bit expSticky = 1'b0;
  bit haveLast  = 1'b0;
  logic [15:0] lastClk = '0;
  logic [15:0] clkCur  = 16'h0100;
  logic [15:0] expPay [N];
  logic [N-1:0] expParErr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] payWord(input int seed, input int i, input bit flip);
    logic [15:0] v;
    v = 16'(seed * 4951) ^ 16'(i * 3855) ^ 16'h00C3;
    if ((^v) != i[0]) v[15] = ~v[15];
    if (flip) v[0] = ~v[0];
    return v;
  endfunction

  task automatic put(input logic en, input logic ext, input logic [15:0] d);
    @(negedge clk);
    rxEn = en; rxErrExt = ext; rxData = d;
  endtask

  // nPay < 0: header only
  task automatic sendFrame(input logic [15:0] hdr, input logic [15:0] cw, input int seed,
                           input int nPay, input int extAt, input logic [N-1:0] flip,
                           input bit flagData);
    put(1'b1, 1'b0, hdr);
    if (nPay >= 0) begin
      put(1'b1, 1'b0, cw);
      for (int i = 0; i < nPay; i++) begin
        logic [15:0] w;
        if (i == extAt) put(1'b0, 1'b1, 16'h5A5A);
        w = payWord(seed, i, flip[i]);
        expPay[i] = w;
        expParErr[i] = flip[i];
        if (flip[i]) expPar++;
        put(1'b1, flagData & i[0], w);
      end
    end
  endtask

  function automatic void noteCommit(input logic [15:0] cw);
    if (haveLast && cw != lastClk + 16'd1) begin
      expSeq++;
      expSticky = 1'b1;
    end
    lastClk  = cw;
    haveLast = 1'b1;
  endfunction

  task automatic checkCounts(input string tag);
    chk(truncCount == CW'(expTrunc), {tag, " R5 truncCount"}, 64'(truncCount), 64'(expTrunc));
    chk(longCount  == CW'(expLong),  {tag, " R6 longCount"},  64'(longCount),  64'(expLong));
    chk(parCount   == CW'(expPar),   {tag, " R7 parCount"},   64'(parCount),   64'(expPar));
    chk(seqCount   == CW'(expSeq),   {tag, " R10 seqCount"},  64'(seqCount),   64'(expSeq));
    chk(ovflCount  == CW'(expOvfl),  {tag, " R9 ovflCount"},  64'(ovflCount),  64'(expOvfl));
    chk(seqSticky  == expSticky,     {tag, " R10 seqSticky"}, 64'(seqSticky),  64'(expSticky));
  endtask

  task automatic checkFrame(input string tag, input logic [15:0] hdr, input logic [15:0] cw);
    chk(frmValid == 1'b1, {tag, " R3 frmValid"}, 64'(frmValid), 64'd1);
    chk(frmHeader == hdr, {tag, " R3 header"}, 64'(frmHeader), 64'(hdr));
    chk(frmClock == cw,   {tag, " R3 clock"},  64'(frmClock),  64'(cw));
    for (int i = 0; i < N; i++)
      chk(frmPayload[i*W +: W] == expPay[i], {tag, " R3 payload word"},
          64'(frmPayload[i*W +: W]), 64'(expPay[i]));
    chk(frmParErr == expParErr, {tag, " R7 parity flags"}, 64'(frmParErr), 64'(expParErr));
  endtask

  task automatic accept(input string tag);
    frmReady = 1'b1;
    @(negedge clk);
    frmReady = 1'b0;
    chk(frmValid == 1'b0, {tag, " R8 valid cleared"}, 64'(frmValid), 64'd0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; rxEn = 1'b1; rxErrExt = 1'b0; rxData = 16'h1111; frmReady = 1'b0;
    expParErr = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(frmValid == 1'b0, "R11 frmValid in reset", 64'(frmValid), 64'd0);
    checkCounts("R11 reset");
    rstN = 1'b1;

    // R2: data before the first non-data word is ignored
    for (int i = 0; i < 15; i++) put(1'b1, 1'b0, 16'(16'h2000 + i));
    put(1'b0, 1'b0, 16'h0);
    @(negedge clk);
    chk(frmValid == 1'b0, "R2 no frame before first gap", 64'(frmValid), 64'd0);
    checkCounts("R2");

    // R1, R3, R4: regular frames with varied gaps, flags and a mid-frame extend
    for (int f = 0; f < 6; f++) begin
      string tag;
      tag = (f == 2) ? "R4 extend skipped" : (f % 2 == 1 ? "R1 flag on data" : "R3 frame");
      for (int g = 0; g < f % 3; g++) put(1'b0, 1'(f % 2), 16'h0);
      sendFrame(16'(16'hA000 + f), clkCur, f + 1, N, (f == 2) ? 5 : -1, '0, 1'(f % 2));
      put(1'b0, 1'(f % 2), 16'h0);
      noteCommit(clkCur);
      @(negedge clk);
      checkFrame(tag, 16'(16'hA000 + f), clkCur);
      accept(tag);
      clkCur = clkCur + 16'd1;
    end
    checkCounts("R3 after frames");

    // R7: parity misses on selected payload words
    sendFrame(16'hB001, clkCur, 9, N, -1, 12'b1010_0000_0011, 1'b0);
    put(1'b0, 1'b0, 16'h0);
    noteCommit(clkCur);
    @(negedge clk);
    checkFrame("R7 parity", 16'hB001, clkCur);
    accept("R7");
    clkCur = clkCur + 16'd1;
    checkCounts("R7");

    // R5: truncation at every point in the frame
    for (int k = -1; k < N; k++) begin
      sendFrame(16'hD000, 16'hDDDD, 30 + k, k, -1, '0, 1'b0);
      put(1'b0, 1'b0, 16'h0);
      @(negedge clk);
      expTrunc++;
      chk(frmValid == 1'b0, "R5 truncated frame dropped", 64'(frmValid), 64'd0);
      chk(truncCount == CW'(expTrunc), "R5 truncCount", 64'(truncCount), 64'(expTrunc));
    end

    // R6: overlong frame, then following data ignored until a gap
    sendFrame(16'hE000, 16'hEEEE, 40, N, -1, '0, 1'b0);
    put(1'b1, 1'b0, 16'h7777);
    put(1'b1, 1'b0, 16'h8888);
    put(1'b0, 1'b0, 16'h0);
    @(negedge clk);
    expLong++;
    chk(frmValid == 1'b0, "R6 overlong dropped", 64'(frmValid), 64'd0);
    checkCounts("R6");
    sendFrame(16'hE001, clkCur, 41, N, -1, '0, 1'b0);
    put(1'b0, 1'b0, 16'h0);
    noteCommit(clkCur);
    @(negedge clk);
    checkFrame("R6 recovery", 16'hE001, clkCur);
    accept("R6");

    // R10: jump, then wrap-around with no fault
    sendFrame(16'hF001, 16'hFFFF, 50, N, -1, '0, 1'b0);
    put(1'b0, 1'b0, 16'h0);
    noteCommit(16'hFFFF);
    @(negedge clk);
    checkFrame("R10 jump", 16'hF001, 16'hFFFF);
    accept("R10");
    checkCounts("R10 jump");
    sendFrame(16'hF002, 16'h0000, 51, N, -1, '0, 1'b0);
    put(1'b0, 1'b1, 16'h0);
    noteCommit(16'h0000);
    @(negedge clk);
    checkFrame("R10 wrap", 16'hF002, 16'h0000);
    accept("R10");
    checkCounts("R10 wrap");
    clkCur = 16'h0001;

    // R9: second frame completes into a stalled slot
    sendFrame(16'hC001, clkCur, 60, N, -1, '0, 1'b0);
    put(1'b0, 1'b0, 16'h0);
    noteCommit(clkCur);
    @(negedge clk);
    checkFrame("R9 first", 16'hC001, clkCur);
    clkCur = clkCur + 16'd1;
    sendFrame(16'hC002, clkCur, 61, N, -1, '0, 1'b0);
    put(1'b0, 1'b0, 16'h0);
    noteCommit(clkCur);
    @(negedge clk);
    expOvfl++;
    chk(frmValid == 1'b1, "R9 held valid", 64'(frmValid), 64'd1);
    chk(frmHeader == 16'hC001, "R9 held header unchanged", 64'(frmHeader), 64'hC001);
    checkCounts("R9 overflow");
    accept("R9");
    clkCur = clkCur + 16'd1;

    // R8/R9: completion in the same cycle as the consumer takes the old frame
    sendFrame(16'hC003, clkCur, 62, N, -1, '0, 1'b0);
    put(1'b0, 1'b0, 16'h0);
    noteCommit(clkCur);
    @(negedge clk);
    clkCur = clkCur + 16'd1;
    sendFrame(16'hC004, clkCur, 63, N, -1, '0, 1'b0);
    put(1'b0, 1'b0, 16'h0);
    frmReady = 1'b1;
    noteCommit(clkCur);
    @(negedge clk);
    frmReady = 1'b0;
    checkFrame("R9 coincident", 16'hC004, clkCur);
    checkCounts("R9 coincident");
    accept("R8");

    finishRun();
  end

endmodule